// File: doc/BRIEF.md
# Command-Triggered Auxiliary Output Timer

This block generates up to four auxiliary enable lines for a memory PHY, for example on-die termination enables. Each line rises a programmable number of memory clock cycles after a read or write command and stays high for a programmable number of cycles. Writes and reads have their own start offset and hold length. Each value comes from one of two timing sets, which the command picks with a select input. Two static lane masks set which lanes follow writes and which follow reads. A third mask forces chosen lanes high while write-leveling calibration runs. The purpose is to make a termination enable rise and fall on the exact cycles that the DRAM's termination-on and termination-off latencies require.

Each lane is a small state machine with three named states. LANE_IDLE means no window is pending. LANE_WAIT means a window is pending and its start cycle has not come yet. LANE_HIGH means the window is running and the lane is high. The transitions are:
- IDLE to WAIT on a command with a nonzero offset.
- IDLE to HIGH on a command with offset 0.
- WAIT to HIGH when the start countdown reaches zero.
- HIGH to IDLE when the end countdown expires.
- WAIT or HIGH back to WAIT or HIGH when a new command merges into the window already there.

The offset and length are latched when the command is accepted. Later changes to the timing inputs do not affect a window that is already scheduled.

Top module: `aux_cmd_timer`

## Requirements
- R1: While reset is low, every lane and every pending window is cleared and `aux_o` is 0 (apart from the write-leveling force of R9). A reset applied in the middle of a pulse drops the lane low at once.
- R2: Take the capture edge of a write command as the start of cycle 0. A write-enabled lane is then high in cycles `off` to `off+dur-1`. Here `off` and `dur` are the selected set's 6-bit write offset and write duration, taken from bits `[6*s +: 6]` of `wr_ofs_i` and `wr_dur_i` for set s.
- R3: A read command uses `rd_ofs_i` and `rd_dur_i` (same field layout as the write inputs) and never uses the write fields.
- R4: `tset_sel_i` = 0 selects set 0 and `tset_sel_i` = 1 selects set 1. The set that is not selected has no effect.
- R5: With an offset of 0, the lane is high in the first cycle after the capture edge.
- R6: A duration of 0 produces no pulse and leaves any window already scheduled unchanged.
- R7: A command that arrives while a window is pending or active merges with it. The lane is then high without a break from the earlier start to the later end.
- R8: A write loads only the lanes set in `WR_LANE_EN` (default 4'b0011). A read loads only the lanes set in `RD_LANE_EN` (default 4'b0110). A lane in neither mask is never driven by commands.
- R9: While `wrlvl_cal_i` is 1, every lane whose `wrlvl_mask_i` bit is 1 is high in that same cycle. Lanes whose mask bit is 0 keep their timed value.
- R10: While `cmd_valid_i` is 0, changes to the command flag, the set select and the timing inputs have no effect on `aux_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is issued in this cycle |
| cmd_is_wr_i | input | 1 | 1 = write command, 0 = read command |
| tset_sel_i | input | SELW (1) | Timing set index for this command |
| wrlvl_cal_i | input | 1 | Write-leveling calibration active |
| wrlvl_mask_i | input | NUM_LANES (4) | Lanes forced high during write leveling |
| wr_ofs_i | input | NUM_SETS*CW (12) | Write start offset for each set |
| wr_dur_i | input | NUM_SETS*CW (12) | Write hold duration for each set |
| rd_ofs_i | input | NUM_SETS*CW (12) | Read start offset for each set |
| rd_dur_i | input | NUM_SETS*CW (12) | Read hold duration for each set |
| aux_o | output | NUM_LANES (4) | Auxiliary enable lines |

## Verification
Two functions can decide the same lane in the same cycle. One is the timed window of a lane that is already high or pending when a second command merges into it. The other is the write-leveling force on a lane that a timed pulse is also driving. The bench provokes the first with back-to-back commands whose gaps are shorter than the window already running, both from a fixed vector table and from random draws. It provokes the second by raising calibration with a mask that covers one lane in a running read pulse and one idle lane. Every cycle, `aux_o` is compared with an absolute-cycle timeline model, ORed with the force mask. The model keeps each lane's window as start and end cycle numbers, not as countdowns.

// File: rtl/aux_timer_pkg.sv
package aux_timer_pkg;

    typedef enum logic [1:0] {
        LANE_IDLE = 2'd0,
        LANE_WAIT = 2'd1,
        LANE_HIGH = 2'd2
    } lane_state_e;

endpackage

// File: rtl/aux_timing_select.sv
module aux_timing_select #(
    parameter int CW       = 6,
    parameter int NUM_SETS = 2,
    parameter int SELW     = 1
) (
    input  logic                   is_wr_i,
    input  logic [SELW-1:0]        sel_i,
    input  logic [NUM_SETS*CW-1:0] wr_ofs_i,
    input  logic [NUM_SETS*CW-1:0] wr_dur_i,
    input  logic [NUM_SETS*CW-1:0] rd_ofs_i,
    input  logic [NUM_SETS*CW-1:0] rd_dur_i,
    output logic [CW-1:0]          ofs_o,
    output logic [CW-1:0]          dur_o
);

    logic [CW-1:0] wr_ofs_set [NUM_SETS];
    logic [CW-1:0] wr_dur_set [NUM_SETS];
    logic [CW-1:0] rd_ofs_set [NUM_SETS];
    logic [CW-1:0] rd_dur_set [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_split
        assign wr_ofs_set[s] = wr_ofs_i[s*CW +: CW];
        assign wr_dur_set[s] = wr_dur_i[s*CW +: CW];
        assign rd_ofs_set[s] = rd_ofs_i[s*CW +: CW];
        assign rd_dur_set[s] = rd_dur_i[s*CW +: CW];
    end

    always_comb begin
        ofs_o = '0;
        dur_o = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (int'(sel_i) == s) begin
                ofs_o = is_wr_i ? wr_ofs_set[s] : rd_ofs_set[s];
                dur_o = is_wr_i ? wr_dur_set[s] : rd_dur_set[s];
            end
        end
    end

endmodule

// File: rtl/aux_lane_tracker.sv
module aux_lane_tracker
    import aux_timer_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] ofs_i,
    input  logic [CW-1:0] dur_i,
    output logic          active_o
);

    localparam int EW = CW + 1;

    logic [EW-1:0] start_q, end_q, start_n, end_n;
    logic [EW-1:0] start_dec, end_dec, cand_start, cand_end;
    lane_state_e   state_q, state_n;

    // Next window: age the counters, then fold in a new command as a hull.
    always_comb begin
        start_dec  = (start_q != '0) ? start_q - 1'b1 : '0;
        end_dec    = (end_q != '0) ? end_q - 1'b1 : '0;
        cand_start = {1'b0, ofs_i};
        cand_end   = {1'b0, ofs_i} + {1'b0, dur_i};
        start_n    = start_dec;
        end_n      = end_dec;
        if (load_i && (dur_i != '0)) begin
            if (end_dec != '0) begin
                start_n = (cand_start < start_dec) ? cand_start : start_dec;
                end_n   = (cand_end > end_dec) ? cand_end : end_dec;
            end else begin
                start_n = cand_start;
                end_n   = cand_end;
            end
        end
        if (end_n == '0)        state_n = LANE_IDLE;
        else if (start_n != '0) state_n = LANE_WAIT;
        else                    state_n = LANE_HIGH;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_IDLE;
            start_q <= '0;
            end_q   <= '0;
        end else begin
            state_q <= state_n;
            start_q <= start_n;
            end_q   <= end_n;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            LANE_HIGH: active_o = 1'b1;
            LANE_WAIT: active_o = 1'b0;
            LANE_IDLE: active_o = 1'b0;
            default:   active_o = 1'b0;
        endcase
    end

    p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_q != '0) |-> (start_q < end_q));

    p_no_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_HIGH && end_q > EW'(1)) |=> (state_q == LANE_HIGH));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && state_q == LANE_IDLE) |=> (state_q == LANE_IDLE));

    p_zero_ofs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ofs_i == '0 && dur_i != '0) |=> active_o);

    p_zero_dur_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && dur_i == '0 && state_q == LANE_IDLE) |=> (state_q == LANE_IDLE));

endmodule

// File: rtl/aux_cmd_timer.sv
module aux_cmd_timer #(
    parameter int               CW         = 6,
    parameter int               NUM_SETS   = 2,
    parameter int               NUM_LANES  = 4,
    parameter logic [NUM_LANES-1:0] WR_LANE_EN = 4'b0011,
    parameter logic [NUM_LANES-1:0] RD_LANE_EN = 4'b0110,
    parameter int               SELW       = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid_i,
    input  logic                   cmd_is_wr_i,
    input  logic [SELW-1:0]        tset_sel_i,
    input  logic                   wrlvl_cal_i,
    input  logic [NUM_LANES-1:0]   wrlvl_mask_i,
    input  logic [NUM_SETS*CW-1:0] wr_ofs_i,
    input  logic [NUM_SETS*CW-1:0] wr_dur_i,
    input  logic [NUM_SETS*CW-1:0] rd_ofs_i,
    input  logic [NUM_SETS*CW-1:0] rd_dur_i,
    output logic [NUM_LANES-1:0]   aux_o
);

    logic [CW-1:0]        sel_ofs, sel_dur;
    logic [NUM_LANES-1:0] lane_load, lane_active, force_mask;

    aux_timing_select #(
        .CW       (CW),
        .NUM_SETS (NUM_SETS),
        .SELW     (SELW)
    ) u_select (
        .is_wr_i  (cmd_is_wr_i),
        .sel_i    (tset_sel_i),
        .wr_ofs_i (wr_ofs_i),
        .wr_dur_i (wr_dur_i),
        .rd_ofs_i (rd_ofs_i),
        .rd_dur_i (rd_dur_i),
        .ofs_o    (sel_ofs),
        .dur_o    (sel_dur)
    );

    assign lane_load = cmd_valid_i ? (cmd_is_wr_i ? WR_LANE_EN : RD_LANE_EN) : '0;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        aux_lane_tracker #(.CW(CW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (lane_load[l]),
            .ofs_i    (sel_ofs),
            .dur_i    (sel_dur),
            .active_o (lane_active[l])
        );
    end

    assign force_mask = wrlvl_cal_i ? wrlvl_mask_i : '0;
    assign aux_o      = lane_active | force_mask;

    p_wrlvl_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrlvl_cal_i |-> ((aux_o & wrlvl_mask_i) == wrlvl_mask_i));

    p_rd_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !cmd_is_wr_i && sel_ofs == '0 && sel_dur != '0)
        |=> ((lane_active & RD_LANE_EN) == RD_LANE_EN));

    p_wr_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_is_wr_i && sel_ofs == '0 && sel_dur != '0)
        |=> ((lane_active & WR_LANE_EN) == WR_LANE_EN));

endmodule

// File: tb/aux_cmd_timer_tb_top.sv
module aux_cmd_timer_tb_top;

    localparam int               CW  = 6;
    localparam int               NS  = 2;
    localparam int               NL  = 4;
    localparam logic [NL-1:0]    WRE = 4'b0011;
    localparam logic [NL-1:0]    RDE = 4'b0110;
    localparam int               NV  = 10;

    // {wr, set, off[5:0], dur[5:0], gap[7:0]}
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 1'b0, 6'd3,  6'd4,  8'd20},
        {1'b0, 1'b0, 6'd5,  6'd2,  8'd20},
        {1'b1, 1'b1, 6'd1,  6'd6,  8'd20},
        {1'b0, 1'b1, 6'd0,  6'd3,  8'd20},
        {1'b1, 1'b0, 6'd0,  6'd0,  8'd10},
        {1'b1, 1'b0, 6'd10, 6'd5,  8'd2},
        {1'b1, 1'b1, 6'd2,  6'd20, 8'd30},
        {1'b0, 1'b0, 6'd63, 6'd63, 8'd5},
        {1'b0, 1'b1, 6'd0,  6'd2,  8'd140},
        {1'b1, 1'b0, 6'd4,  6'd0,  8'd3}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic           cmd_is_wr = 1'b0;
    logic [0:0]     tset_sel = '0;
    logic           wrlvl_cal = 1'b0;
    logic [NL-1:0]  wrlvl_mask = '0;
    logic [NS*CW-1:0] wr_ofs = '0, wr_dur = '0, rd_ofs = '0, rd_dur = '0;
    logic [NL-1:0]  aux_o;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    m_st [NL];
    int    m_en [NL];
    int    m_off = 0;
    int    m_dur = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    aux_cmd_timer #(
        .CW(CW), .NUM_SETS(NS), .NUM_LANES(NL), .WR_LANE_EN(WRE), .RD_LANE_EN(RDE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_is_wr_i(cmd_is_wr),
        .tset_sel_i(tset_sel), .wrlvl_cal_i(wrlvl_cal), .wrlvl_mask_i(wrlvl_mask),
        .wr_ofs_i(wr_ofs), .wr_dur_i(wr_dur), .rd_ofs_i(rd_ofs), .rd_dur_i(rd_dur),
        .aux_o(aux_o)
    );

    // Timeline model in absolute cycle numbers; cycle cyc begins at its edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0;
            for (int l = 0; l < NL; l++) begin m_st[l] = 0; m_en[l] = 0; end
        end else begin
            cyc = cyc + 1;
            if (cmd_valid && m_dur > 0) begin
                for (int l = 0; l < NL; l++) begin
                    if (cmd_is_wr ? WRE[l] : RDE[l]) begin
                        if (m_en[l] > cyc) begin
                            if (cyc + m_off < m_st[l]) m_st[l] = cyc + m_off;
                            if (cyc + m_off + m_dur > m_en[l]) m_en[l] = cyc + m_off + m_dur;
                        end else begin
                            m_st[l] = cyc + m_off;
                            m_en[l] = cyc + m_off + m_dur;
                        end
                    end
                end
            end
        end
    end

    function automatic logic [NL-1:0] expected();
        logic [NL-1:0] e;
        for (int l = 0; l < NL; l++) e[l] = rst_n && (m_st[l] <= cyc) && (cyc < m_en[l]);
        return e | (wrlvl_cal ? wrlvl_mask : '0);
    endfunction

    task automatic tick();
        logic [NL-1:0] e;
        @(negedge clk);
        e = expected();
        checks++;
        if (aux_o !== e) begin
            errors++;
            $display("FAIL %s cycle %0d: aux_o=%b expected %b", tag, cyc, aux_o, e);
        end
    endtask

    task automatic scramble();
        cmd_is_wr = 1'($urandom);
        tset_sel  = 1'($urandom);
        wr_ofs = NS*CW'($urandom); wr_dur = NS*CW'($urandom);
        rd_ofs = NS*CW'($urandom); rd_dur = NS*CW'($urandom);
    endtask

    // Drive one command; the unselected set and the other command type carry decoys.
    task automatic issue(input logic wr, input logic set, input int off, input int dur);
        for (int s = 0; s < NS; s++) begin
            wr_ofs[s*CW +: CW] = (s == int'(set) && wr)  ? CW'(off) : CW'(off ^ 21);
            wr_dur[s*CW +: CW] = (s == int'(set) && wr)  ? CW'(dur) : CW'(dur ^ 10);
            rd_ofs[s*CW +: CW] = (s == int'(set) && !wr) ? CW'(off) : CW'(off ^ 13);
            rd_dur[s*CW +: CW] = (s == int'(set) && !wr) ? CW'(dur) : CW'(dur ^ 7);
        end
        cmd_is_wr = wr;
        tset_sel  = set;
        m_off     = off;
        m_dur     = dur;
        cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            scramble();
            tick();
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5, 6: return "R7";
            7, 8: return "R7";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: outputs low during reset
        tag = "R1";
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        tick();

        // Table walk: R2 R3 R4 R5 R6 R7 R8 (lane masks judged in every compare), R10 in gaps
        for (int i = 0; i < NV; i++) begin
            tag = vec_tag(i);
            issue(VEC[i][21], VEC[i][20], int'(VEC[i][19:14]), int'(VEC[i][13:8]));
            idle(int'(VEC[i][7:0]));
        end

        // R8: a read never touches lane 0, a write never touches lane 2
        tag = "R8";
        issue(1'b0, 1'b0, 0, 4);
        idle(6);
        issue(1'b1, 1'b1, 0, 4);
        idle(6);

        // R6: zero duration during an active window leaves it unchanged
        tag = "R6";
        issue(1'b1, 1'b0, 1, 8);
        idle(2);
        issue(1'b1, 1'b0, 0, 0);
        idle(10);

        // R9: calibration force over a running read pulse and an idle lane
        tag = "R9";
        issue(1'b0, 1'b0, 0, 12);
        idle(2);
        wrlvl_mask = 4'b1010;
        wrlvl_cal  = 1'b1;
        idle(15);
        wrlvl_cal  = 1'b0;
        idle(3);

        // R10: long quiet stretch with scrambled fields
        tag = "R10";
        idle(40);

        // R7: random back-to-back traffic
        tag = "R7";
        for (int i = 0; i < 80; i++) begin
            issue(1'($urandom), 1'($urandom), int'($urandom_range(0, 63)),
                  int'($urandom_range(0, 63)));
            idle(int'($urandom_range(0, 20)));
        end
        idle(140);

        // R1: reset in the middle of a pulse drops the lanes at once
        tag = "R1";
        issue(1'b1, 1'b0, 0, 30);
        idle(3);
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        idle(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule